// File: doc/BRIEF.md
# Cascadable Fixed-Priority Interrupt Controller

The block collects hardware interrupt requests and presents them one at a time to a processor. It uses fixed priority, so line 0 is always the most urgent. A processor acknowledge returns an 8-bit vector that identifies the source. The level stays marked as in service until software writes a specific end-of-interrupt command for it.

Each controller unit has eight request lines and a byte-wide register port with two addresses. Writing the odd address loads the mask. Writing the even address issues commands. The top level holds two units, a primary and a secondary. The request output of the secondary drives line 2 of the primary, so the pair serves fifteen sources. The two units return vectors from separate vector bases. A source on the secondary is retired only after an end-of-interrupt to the secondary and then one to the primary for line 2.

A bus select input chooses which unit a register access addresses. The processor sees a single interrupt output and a single acknowledge input. It receives the vector and a one-cycle valid strobe on the cycle after the acknowledge.

Top module: `irq_cascade_pair`

## Requirements
- R1: After reset both masks read 0xFF (every line blocked), no request is pending, nothing is in service, `intr_o` is low and `vec_valid_o` is low.
- R2: A write with `addr_i`=1 loads the selected unit's mask, where bit n = 1 blocks line n. From the next cycle the new mask governs `intr_o`. A read with `addr_i`=1 returns the selected mask, and a read with `addr_i`=0 returns 0x00.
- R3: A request line latches on a 0-to-1 transition of its input. It stays pending while masked or blocked until it is acknowledged, even after the input falls.
- R4: Among the unmasked pending lines, the lowest line number is the one presented and acknowledged.
- R5: A pending line is presented on `intr_o` only when no line of equal or lower number is in service in that unit.
- R6: When `inta_i` is high for one cycle while a request is presented, that level enters service and its request latch clears. On the next cycle `vec_o` holds the vector and `vec_valid_o` is high for that one cycle.
- R7: A command-port write whose bits 7:5 are 011 clears the in-service bit named by bits 2:0 and no other bit. Any other command byte changes nothing.
- R8: Primary line n returns vector 0x08 + n. Secondary line m (system line 8 + m, on `irq_i[8+m]`) returns vector 0x70 + m.
- R9: A secondary request reaches the processor through primary line 2. After it is acknowledged, no further secondary request and no primary line numbered 2 or higher is presented until end-of-interrupt commands have gone to the secondary (0x60 + m) and to the primary (0x62).
- R10: An acknowledge while nothing is presented returns vector 0x0F and changes no pending or in-service state.
- R11: `irq_i[2]` is ignored, because primary line 2 is fed only by the secondary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 16 | Request lines; bits 7:0 go to the primary (bit 2 unused) and bits 15:8 to the secondary |
| sel_sec_i | input | 1 | Register access targets the secondary when 1, the primary when 0 |
| addr_i | input | 1 | 0 selects the command port, 1 selects the mask port |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (mask, or 0x00 for the command port) |
| intr_o | output | 1 | Interrupt request to the processor |
| inta_i | input | 1 | Acknowledge strobe, one cycle |
| vec_o | output | 8 | Vector returned for the last acknowledge |
| vec_valid_o | output | 1 | High on the cycle after an acknowledge |

## Verification
Assertions check on every cycle that the acknowledged level enters service and that a mask write is in force on the next cycle. They also check that an end-of-interrupt clears only its target bit and that nothing is presented while a level of equal or higher priority is in service. Further checks cover a masked latch holding its request, a cascade acknowledge only when the secondary is requesting, and the spurious vector for an empty acknowledge. Only the bench scenarios show the actual vector numbers and the two-step retirement of a secondary source. They also show that `irq_i[2]` is ignored and how masking, nesting and priority interact over long random sequences.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_LINES = 8;
  localparam int unsigned LVL_W     = $clog2(NUM_LINES);
  localparam int unsigned VEC_W     = 8;
  localparam logic [2:0]  EOI_OP    = 3'b011;

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [VEC_W-1:0] vec_t;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int unsigned N_LINES = 8,
  parameter logic [N_LINES-1:0] LEVEL_MASK = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] line_i,
  input  logic [N_LINES-1:0] clr_i,
  output logic [N_LINES-1:0] req_o
);
  logic unused_clr;
  assign unused_clr = ^(clr_i & LEVEL_MASK);

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    if (LEVEL_MASK[g]) begin : g_level
      // level line: pending exactly while the input is high
      assign req_o[g] = line_i[g];
    end else begin : g_edge
      logic prev_q, req_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          prev_q <= 1'b0;
          req_q  <= 1'b0;
        end else begin
          prev_q <= line_i[g];
          if (line_i[g] && !prev_q) req_q <= 1'b1;
          else if (clr_i[g])        req_q <= 1'b0;
        end
      end
      assign req_o[g] = req_q;

      a_r3_pending_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_q && !clr_i[g]) |=> req_q)
        else $error("R3 pending request lost on line %0d", g);
    end
  end
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve
  import irq_pkg::*;
#(
  parameter int unsigned N_LINES = 8,
  localparam int unsigned LW = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] pend_i,
  input  logic [N_LINES-1:0] isr_i,
  output logic               present_o,
  output logic [LW-1:0]      best_o
);
  logic          any_pend, any_isr;
  logic [LW-1:0] top_isr;

  always_comb begin
    any_pend = 1'b0;
    any_isr  = 1'b0;
    best_o   = '0;
    top_isr  = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        any_pend = 1'b1;
        best_o   = LW'(i);
      end
      if (isr_i[i]) begin
        any_isr = 1'b1;
        top_isr = LW'(i);
      end
    end
    present_o = any_pend && (!any_isr || (best_o < top_isr));
  end
endmodule

// File: rtl/irq_unit.sv
module irq_unit
  import irq_pkg::*;
#(
  parameter int unsigned N_LINES  = 8,
  parameter logic [7:0]  VEC_BASE = 8'h08,
  parameter bit          IS_SEC   = 1'b0,
  parameter int unsigned CAS_LINE = 2,
  localparam int unsigned LW = $clog2(N_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] line_i,
  input  logic               wr_i,
  input  logic               addr_i,
  input  logic [7:0]         wdata_i,
  output logic [N_LINES-1:0] mask_o,
  input  logic               inta_i,
  output logic               intr_o,
  output logic [LW-1:0]      best_o,
  output logic [7:0]         vec_o,
  output logic               vec_valid_o
);
  // a primary sees its cascade line as a level, a secondary has none
  localparam logic [N_LINES-1:0] LEVEL_MASK =
    IS_SEC ? '0 : ({{(N_LINES-1){1'b0}}, 1'b1} << CAS_LINE);

  logic [N_LINES-1:0] req, pend, mask_q, isr_q, isr_d, clr, upto_best;
  logic               present, ack_hit, eoi_hit;
  logic [LW-1:0]      best, eoi_lvl;
  logic [7:0]         vec_q;
  logic               valid_q;

  irq_req_latch #(.N_LINES(N_LINES), .LEVEL_MASK(LEVEL_MASK)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .clr_i  (clr),
    .req_o  (req)
  );

  assign pend = req & ~mask_q;

  irq_prio_resolve #(.N_LINES(N_LINES)) u_resolve (
    .pend_i    (pend),
    .isr_i     (isr_q),
    .present_o (present),
    .best_o    (best)
  );

  assign ack_hit = inta_i && present;
  assign clr     = ack_hit ? (N_LINES'(1) << best) : '0;
  assign eoi_hit = wr_i && !addr_i && (wdata_i[7:5] == EOI_OP);
  assign eoi_lvl = wdata_i[LW-1:0];

  always_comb begin
    isr_d = isr_q;
    if (eoi_hit) isr_d[eoi_lvl] = 1'b0;
    if (ack_hit) isr_d[best]    = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '1;
      isr_q   <= '0;
      vec_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (wr_i && addr_i) mask_q <= wdata_i[N_LINES-1:0];
      isr_q   <= isr_d;
      valid_q <= inta_i;
      if (inta_i)
        vec_q <= present ? VEC_BASE + 8'(best) : VEC_BASE + 8'(N_LINES - 1);
    end
  end

  assign mask_o      = mask_q;
  assign intr_o      = present;
  assign best_o      = best;
  assign vec_o       = vec_q;
  assign vec_valid_o = valid_q;

  always_comb
    for (int i = 0; i < N_LINES; i++) upto_best[i] = (i <= int'(best));

  a_r2_mask_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i) |=> (mask_q == $past(wdata_i[N_LINES-1:0])))
    else $error("R2 mask not loaded");

  a_r6_ack_in_service: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_hit |=> isr_q[$past(best)])
    else $error("R6 acknowledged level not in service");

  a_r5_nest_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intr_o |-> ((isr_q & upto_best) == '0))
    else $error("R5 presented under equal or higher in-service level");

  a_r7_eoi_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_hit && !(ack_hit && best == eoi_lvl)) |=> !isr_q[$past(eoi_lvl)])
    else $error("R7 end-of-interrupt did not clear target");

  a_r7_eoi_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_hit |=> (($past(isr_q) & ~(N_LINES'(1) << $past(eoi_lvl)) & ~isr_q) == '0))
    else $error("R7 end-of-interrupt cleared another level");
endmodule

// File: rtl/irq_cascade_pair.sv
module irq_cascade_pair
  import irq_pkg::*;
#(
  parameter int unsigned N_LINES  = NUM_LINES,
  parameter logic [7:0]  PRI_BASE = 8'h08,
  parameter logic [7:0]  SEC_BASE = 8'h70,
  parameter int unsigned CAS_LINE = 2,
  localparam int unsigned LW = $clog2(N_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2*N_LINES-1:0] irq_i,
  input  logic                 sel_sec_i,
  input  logic                 addr_i,
  input  logic                 wr_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           rdata_o,
  output logic                 intr_o,
  input  logic                 inta_i,
  output logic [7:0]           vec_o,
  output logic                 vec_valid_o
);
  logic [N_LINES-1:0] pri_lines, pri_mask, sec_mask;
  logic [LW-1:0]      pri_best, sec_best;
  logic [7:0]         pri_vec, sec_vec;
  logic               pri_intr, sec_intr, pri_valid, sec_valid, sec_ack, cas_q;
  logic               unused_sig;

  assign unused_sig = irq_i[CAS_LINE] ^ sec_valid ^ (^sec_best);

  always_comb begin
    pri_lines           = irq_i[N_LINES-1:0];
    pri_lines[CAS_LINE] = sec_intr;
  end

  assign sec_ack = inta_i && pri_intr && (pri_best == LW'(CAS_LINE));

  irq_unit #(.N_LINES(N_LINES), .VEC_BASE(PRI_BASE), .IS_SEC(1'b0), .CAS_LINE(CAS_LINE)) u_pri (
    .clk_i, .rst_ni,
    .line_i      (pri_lines),
    .wr_i        (wr_i && !sel_sec_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .mask_o      (pri_mask),
    .inta_i      (inta_i),
    .intr_o      (pri_intr),
    .best_o      (pri_best),
    .vec_o       (pri_vec),
    .vec_valid_o (pri_valid)
  );

  irq_unit #(.N_LINES(N_LINES), .VEC_BASE(SEC_BASE), .IS_SEC(1'b1), .CAS_LINE(CAS_LINE)) u_sec (
    .clk_i, .rst_ni,
    .line_i      (irq_i[2*N_LINES-1:N_LINES]),
    .wr_i        (wr_i && sel_sec_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .mask_o      (sec_mask),
    .inta_i      (sec_ack),
    .intr_o      (sec_intr),
    .best_o      (sec_best),
    .vec_o       (sec_vec),
    .vec_valid_o (sec_valid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cas_q <= 1'b0;
    else if (inta_i) cas_q <= sec_ack;
  end

  assign rdata_o     = addr_i ? 8'(sel_sec_i ? sec_mask : pri_mask) : 8'h00;
  assign intr_o      = pri_intr;
  assign vec_o       = cas_q ? sec_vec : pri_vec;
  assign vec_valid_o = pri_valid;

  a_r9_cascade_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_ack |-> sec_intr)
    else $error("R9 cascade acknowledge without secondary request");

  a_r10_spurious_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && !pri_intr) |=> (vec_valid_o && vec_o == PRI_BASE + 8'(N_LINES - 1)))
    else $error("R10 spurious vector wrong");
endmodule

// File: tb/irq_cascade_pair_tb.sv
module irq_cascade_pair_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] irq = '0;
  logic        sel_sec = 1'b0, addr = 1'b0, wr = 1'b0, inta = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, vec;
  logic        intr, vec_valid;

  int n_chk = 0, n_fail = 0;
  bit done  = 1'b0;

  logic [7:0] mr[2], mm[2], ms[2], mp[2];
  logic [7:0] mvec;
  logic       mvalid;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_cascade_pair u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .sel_sec_i(sel_sec), .addr_i(addr),
    .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata), .intr_o(intr), .inta_i(inta),
    .vec_o(vec), .vec_valid_o(vec_valid)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit pres(input logic [7:0] r, input logic [7:0] m,
                              input logic [7:0] s, output int b);
    logic [7:0] p;
    int si;
    p = r & ~m;
    b = 8; si = 8;
    for (int i = 7; i >= 0; i--) begin
      if (p[i]) b = i;
      if (s[i]) si = i;
    end
    return (b < 8) && (b < si);
  endfunction

  function automatic bit model_intr();
    int sb, pb;
    logic [7:0] pr;
    pr = mr[0];
    pr[2] = pres(mr[1], mm[1], ms[1], sb);
    return pres(pr, mm[0], ms[0], pb);
  endfunction

  task automatic upd(input int u, input bit ack, input int best, input logic [7:0] lines);
    logic [7:0] c;
    c = ack ? (8'd1 << best) : 8'd0;
    if (wr && (sel_sec == u[0]) && addr) mm[u] = wdata;
    if (wr && (sel_sec == u[0]) && !addr && wdata[7:5] == 3'b011) ms[u][wdata[2:0]] = 1'b0;
    if (ack) ms[u][best] = 1'b1;
    mr[u] = (mr[u] & ~c) | (lines & ~mp[u]);
    mp[u] = lines;
  endtask

  task automatic tick();
    int sb, pb;
    bit sp, pp, sack;
    logic [7:0] pr;
    #1;
    if (!wr) check(rdata, addr ? mm[sel_sec] : 8'h00, "R2 read");
    sp = pres(mr[1], mm[1], ms[1], sb);
    pr = mr[0]; pr[2] = sp;
    pp = pres(pr, mm[0], ms[0], pb);
    sack = inta && pp && pb == 2;
    if (inta) mvec = sack ? 8'h70 + 8'(sb) : (pp ? 8'h08 + 8'(pb) : 8'h0F);
    mvalid = inta;
    upd(0, inta && pp, pb, irq[7:0]);
    upd(1, sack, sb, irq[15:8]);
    @(posedge clk); #1;
    check({7'd0, intr}, {7'd0, model_intr()}, "R5 intr");
    check({7'd0, vec_valid}, {7'd0, mvalid}, "R6 valid");
    if (mvalid) check(vec, mvec, "R6 vec");
  endtask

  task automatic wreg(input bit s, input bit a, input logic [7:0] d);
    sel_sec = s; addr = a; wdata = d; wr = 1'b1;
    tick();
    wr = 1'b0; addr = 1'b0;
  endtask

  task automatic rd(input bit s, input logic [7:0] exp, input string tag);
    sel_sec = s; addr = 1'b1; #1;
    check(rdata, exp, tag);
    addr = 1'b0;
  endtask

  task automatic pulse(input int n);
    irq[n] = 1'b1; tick();
    irq[n] = 1'b0; tick();
  endtask

  task automatic ack();
    inta = 1'b1; tick(); inta = 1'b0;
  endtask

  initial begin
    for (int u = 0; u < 2; u++) begin
      mr[u] = '0; mm[u] = 8'hFF; ms[u] = '0; mp[u] = '0;
    end
    mvec = '0; mvalid = 1'b0;
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check({7'd0, intr}, 8'd0, "R1 intr after reset");
    check({7'd0, vec_valid}, 8'd0, "R1 valid after reset");
    rd(0, 8'hFF, "R1 primary mask reset");
    rd(1, 8'hFF, "R1 secondary mask reset");
    tick();

    wreg(0, 1, 8'h00);
    rd(0, 8'h00, "R2 mask readback");
    pulse(5);
    check({7'd0, intr}, 8'd1, "R3 edge latched");
    pulse(1);
    ack();
    check(vec, 8'h09, "R4 lowest line wins");
    check({7'd0, vec_valid}, 8'd1, "R6 valid strobe");
    check({7'd0, intr}, 8'd0, "R5 line5 blocked by line1 in service");
    tick();
    check({7'd0, vec_valid}, 8'd0, "R6 valid one cycle");
    wreg(0, 0, 8'h20);
    check({7'd0, intr}, 8'd0, "R7 other command ignored");
    wreg(0, 0, 8'h65);
    check({7'd0, intr}, 8'd0, "R7 eoi of idle level leaves line1");
    wreg(0, 0, 8'h61);
    check({7'd0, intr}, 8'd1, "R7 eoi line1 releases line5");
    ack();
    check(vec, 8'h0D, "R8 primary vector line5");
    wreg(0, 0, 8'h65);

    wreg(0, 1, 8'h10);
    pulse(4);
    check({7'd0, intr}, 8'd0, "R3 masked request held back");
    wreg(0, 1, 8'h00);
    check({7'd0, intr}, 8'd1, "R2 unmask effective next cycle");
    ack();
    check(vec, 8'h0C, "R3 masked request kept pending");
    wreg(0, 0, 8'h64);

    pulse(2);
    check({7'd0, intr}, 8'd0, "R11 irq_i[2] ignored");
    ack();
    check(vec, 8'h0F, "R10 spurious vector");
    pulse(6);
    ack();
    check(vec, 8'h0E, "R10 no state change after spurious");
    wreg(0, 0, 8'h66);

    wreg(1, 1, 8'h00);
    pulse(9);
    check({7'd0, intr}, 8'd1, "R9 secondary reaches primary");
    ack();
    check(vec, 8'h71, "R8 secondary vector line1");
    pulse(12);
    check({7'd0, intr}, 8'd0, "R9 secondary nested block");
    wreg(1, 0, 8'h61);
    check({7'd0, intr}, 8'd0, "R9 primary line2 still in service");
    wreg(0, 0, 8'h62);
    check({7'd0, intr}, 8'd1, "R9 released after both eois");
    ack();
    check(vec, 8'h74, "R9 secondary vector line4");
    wreg(1, 0, 8'h64);
    wreg(0, 0, 8'h62);

    for (int k = 0; k < 4000; k++) begin
      irq = irq ^ (16'($urandom) & 16'($urandom) & 16'($urandom));
      inta = ($urandom % 6) == 0;
      wr = ($urandom % 5) == 0;
      sel_sec = $urandom % 2;
      addr = $urandom % 2;
      if (wr && addr) wdata = 8'($urandom) & 8'($urandom);
      else if (wr) wdata = (($urandom % 8) == 0) ? 8'($urandom) : {3'b011, 5'($urandom)};
      tick();
    end
    inta = 1'b0; wr = 1'b0;
    tick();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule